// File: doc/BRIEF.md
# Cut-Through Serial Frame Router

This block joins six clocked serial links and moves whole frames between them. Each link delivers one bit per strobe, and a frame-valid line stays high for the length of a frame. The block collects the first four bits of a frame as a destination address. It looks the address up in a sixteen-entry table, and the entry names either an outgoing link, local delivery, or discard.

A frame bound for another link starts leaving on that link in the cycle after its fourth bit arrives. The four address bits go out first, one per cycle, and every later bit follows as soon as it comes in. Only the frame is switched, so the bits are never held for the whole frame.

A frame bound for the local node is kept in a 64-bit buffer, and an interrupt is raised when the frame ends. The host writes the routing table and reads the buffer through plain parallel register ports. A frame is dropped when its target is busy. Each receiving link then counts the drop in its own saturating counter.

Top module: `frame_router`

## Requirements
- R1: After reset every outgoing frame-valid and strobe line is low, `irq` is low, `frame_len` is 0 and all drop counters read 0. Every table entry holds code 6.
- R2: The first four bits of a frame form the address, with the first bit received as its most significant bit. The address selects a table entry. Code values 0 to 5 name an outgoing link, 7 means local delivery and 6 means discard.
- R3: For a routed frame, `tx_frm` and the first strobe of the chosen link appear in the cycle after the strobe that carried the fourth address bit. The link then carries the whole frame in order, including the address bits, at one queued bit per cycle.
- R4: Once the queued bits have drained, a later bit leaves on the outgoing link in the cycle after its incoming strobe.
- R5: `tx_frm` falls only after the last bit of the frame has been strobed out. The link is then free for a new frame.
- R6: A frame whose outgoing link already carries another frame is dropped. The drop counter of the receiving link goes up by one, and the frame already in progress is delivered intact.
- R7: When several frames claim the same free target in the same cycle, the lowest-numbered receiving link wins. Each of the others is dropped and counted.
- R8: A frame with code 7 is stored whole. Bit k of `frame_data` holds the k-th bit received, with the address in bits 0 to 3. `frame_len` gives the bit count, and `irq` rises after frame-valid falls.
- R9: `irq` stays high until `irq_ack` is pulsed. Until then, further local frames are dropped and counted, and `frame_data` and `frame_len` stay unchanged.
- R10: A local frame longer than 64 bits keeps its first 64 bits, and `frame_len` reads 64.
- R11: A frame with code 6 produces no outgoing frame and no drop count. A frame that ends before its fourth bit has no effect on the next frame.
- R12: A cycle with `tbl_we` high writes `tbl_code` into entry `tbl_idx`, and the new entry applies to later frames.
- R13: Each drop counter stops at 255 and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every link is sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 6 | Per-link bit strobe |
| rx_dat | input | 6 | Per-link data bit, valid with its strobe |
| rx_frm | input | 6 | Per-link frame-valid; falling ends a frame |
| tx_stb | output | 6 | Per-link outgoing bit strobe |
| tx_dat | output | 6 | Per-link outgoing data bit |
| tx_frm | output | 6 | Per-link outgoing frame-valid |
| tbl_we | input | 1 | Routing table write enable |
| tbl_idx | input | 4 | Table entry (address) to write |
| tbl_code | input | 3 | Code to write |
| irq | output | 1 | Local frame waiting |
| irq_ack | input | 1 | Host acknowledge; clears `irq` |
| frame_data | output | 64 | Local frame bits, first bit in bit 0 |
| frame_len | output | 7 | Local frame length in bits |
| drop_cnt | output | 48 | Drop counters, 8 bits per link, link 0 lowest |

## Verification
The bench times the first outgoing bit against the fourth address strobe. A router that waited one more bit or did not replay the address would misplace or lose the first bits. It holds a target busy while a second frame arrives, and it also starts two frames on the same cycle. A router without the busy test would splice two frames onto one link, and one with the wrong tie order would forward the wrong link's bits. It also sends a second local frame while the interrupt is pending, overruns the 64-bit buffer, cuts a frame short inside its address, and drives one counter past its limit. Mistakes there show up as an overwritten buffer, a wrapped length or count, or a shifted address on the next frame.

// File: rtl/frame_router.sv
module frame_router #(
  parameter int NP  = 6,
  parameter int AW  = 4,
  parameter int CW  = 3,
  parameter int BUF = 64,
  parameter int DCW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NP-1:0]            rx_stb,
  input  logic [NP-1:0]            rx_dat,
  input  logic [NP-1:0]            rx_frm,
  output logic [NP-1:0]            tx_stb,
  output logic [NP-1:0]            tx_dat,
  output logic [NP-1:0]            tx_frm,
  input  logic                     tbl_we,
  input  logic [AW-1:0]            tbl_idx,
  input  logic [CW-1:0]            tbl_code,
  output logic                     irq,
  input  logic                     irq_ack,
  output logic [BUF-1:0]           frame_data,
  output logic [$clog2(BUF+1)-1:0] frame_len,
  output logic [NP*DCW-1:0]        drop_cnt
);
  localparam int NT = 1 << AW;
  localparam int QD = AW + 1;
  localparam int QW = $clog2(QD + 1);
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(BUF + 1);
  localparam logic [CW-1:0] LOCAL = '1;
  localparam logic [CW-1:0] DISC  = LOCAL - 1'b1;
  localparam logic [CW-1:0] NPC   = CW'(NP);
  localparam logic [QW-1:0] HLAST = QW'(AW - 1);
  localparam logic [QW-1:0] QAW   = QW'(AW);
  localparam logic [LW-1:0] BUFL  = LW'(BUF);
  localparam logic [LW-1:0] AWL   = LW'(AW);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_FWD, S_FIN, S_LOC, S_DROP} state_t;

  logic [CW-1:0]  tbl   [NT];
  state_t         st    [NP];
  logic [AW-2:0]  sr    [NP];
  logic [QW-1:0]  hc    [NP];
  logic [QD-1:0]  q     [NP];
  logic [QW-1:0]  qc    [NP];
  logic [PW-1:0]  tgt   [NP];
  logic [DCW-1:0] dcnt  [NP];
  logic [PW-1:0]  own_i [NP];
  logic [NP-1:0]  own_v;
  logic           lbusy;
  logic [LW-1:0]  llen;

  logic [NP-1:0]         bit_in, dec, grant, pop;
  logic [AW-1:0]         addr  [NP];
  logic [CW-1:0]         code  [NP];
  logic [QD-1:0]         qn    [NP];
  logic [QD-1:0]         qload [NP];
  logic [QW-1:0]         qcn   [NP];
  logic [(1<<CW)-1:0]    busy_v;

  always_comb begin
    busy_v = '0;
    busy_v[NP-1:0] = own_v;
    busy_v[LOCAL] = lbusy;
    for (int i = 0; i < NP; i++) begin
      bit_in[i] = rx_stb[i] & rx_frm[i];
      addr[i]   = {sr[i], rx_dat[i]};
      code[i]   = tbl[addr[i]];
      dec[i]    = (st[i] == S_HDR) && bit_in[i] && (hc[i] == HLAST);
      for (int k = 0; k < AW; k++) qload[i][k] = addr[i][AW-1-k];
      qload[i][AW] = 1'b0;
      pop[i] = (st[i] == S_FWD || st[i] == S_FIN) && (qc[i] != '0);
      qn[i]  = pop[i] ? (q[i] >> 1) : q[i];
      qcn[i] = qc[i] - QW'(pop[i]);
      if (st[i] == S_FWD && bit_in[i]) begin
        for (int k = 0; k < QD; k++)
          if (QW'(k) == qcn[i]) qn[i][k] = rx_dat[i];
        qcn[i] = qcn[i] + QW'(1);
      end
    end
    for (int i = 0; i < NP; i++) begin
      grant[i] = dec[i] && (code[i] < NPC || code[i] == LOCAL) && !busy_v[code[i]];
      for (int j = 0; j < i; j++)
        if (dec[j] && code[j] == code[i]) grant[i] = 1'b0;
    end
    for (int o = 0; o < NP; o++) begin
      tx_frm[o] = own_v[o];
      tx_stb[o] = own_v[o] && (qc[own_i[o]] != '0);
      tx_dat[o] = own_v[o] && q[own_i[o]][0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) tbl[t] <= DISC;
      for (int i = 0; i < NP; i++) begin
        st[i] <= S_IDLE; sr[i] <= '0; hc[i] <= '0; q[i] <= '0; qc[i] <= '0;
        tgt[i] <= '0; dcnt[i] <= '0; own_i[i] <= '0;
      end
      own_v <= '0; lbusy <= 1'b0; irq <= 1'b0; llen <= '0;
      frame_data <= '0; frame_len <= '0;
    end else begin
      if (tbl_we) tbl[tbl_idx] <= tbl_code;
      if (irq && irq_ack) begin
        irq <= 1'b0;
        lbusy <= 1'b0;
      end
      for (int i = 0; i < NP; i++) begin
        q[i]  <= qn[i];
        qc[i] <= qcn[i];
        case (st[i])
          S_IDLE:
            if (bit_in[i]) begin
              sr[i] <= (AW-1)'({sr[i], rx_dat[i]});
              hc[i] <= QW'(1);
              st[i] <= S_HDR;
            end
          S_HDR:
            if (!rx_frm[i]) st[i] <= S_IDLE;
            else if (dec[i]) begin
              tgt[i] <= code[i][PW-1:0];
              if (grant[i] && code[i] == LOCAL) begin
                st[i] <= S_LOC;
                lbusy <= 1'b1;
                llen  <= AWL;
                for (int k = 0; k < AW; k++) frame_data[k] <= addr[i][AW-1-k];
              end else if (grant[i]) begin
                st[i] <= S_FWD;
                q[i]  <= qload[i];
                qc[i] <= QAW;
                own_v[code[i][PW-1:0]] <= 1'b1;
                own_i[code[i][PW-1:0]] <= PW'(i);
              end else begin
                st[i] <= S_DROP;
                if ((code[i] < NPC || code[i] == LOCAL) && dcnt[i] != '1)
                  dcnt[i] <= dcnt[i] + DCW'(1);
              end
            end else if (bit_in[i]) begin
              sr[i] <= (AW-1)'({sr[i], rx_dat[i]});
              hc[i] <= hc[i] + QW'(1);
            end
          S_FWD:
            if (!rx_frm[i]) st[i] <= S_FIN;
          S_FIN:
            if (qc[i] == '0) begin
              st[i] <= S_IDLE;
              own_v[tgt[i]] <= 1'b0;
            end
          S_LOC: begin
            if (bit_in[i] && llen < BUFL) begin
              for (int k = 0; k < BUF; k++)
                if (LW'(k) == llen) frame_data[k] <= rx_dat[i];
              llen <= llen + LW'(1);
            end
            if (!rx_frm[i]) begin
              st[i] <= S_IDLE;
              irq <= 1'b1;
              frame_len <= llen;
            end
          end
          S_DROP:
            if (!rx_frm[i]) st[i] <= S_IDLE;
          default: st[i] <= S_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_port
    assign drop_cnt[g*DCW +: DCW] = dcnt[g];

    // R3
    owner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_v[g] |-> (st[own_i[g]] == S_FWD || st[own_i[g]] == S_FIN));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_frm[g]) |-> $past(!tx_stb[g]));

    // R13
    drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt[g] >= $past(dcnt[g]));
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> irq);

  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack |=> $stable(frame_data) && $stable(frame_len));

  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= BUFL);
endmodule

// File: tb/frame_router_test.sv
`timescale 1ns/1ps
module frame_router_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] rx_stb, rx_dat, rx_frm;
  logic [5:0] tx_stb, tx_dat, tx_frm;
  logic tbl_we;
  logic [3:0] tbl_idx;
  logic [2:0] tbl_code;
  logic irq, irq_ack;
  logic [63:0] frame_data;
  logic [6:0] frame_len;
  logic [47:0] drop_cnt;

  int nchk = 0, nfail = 0, cyc = 0;
  int clen [6], starts [6], first_cyc [6], last_cyc [6];
  logic [127:0] cap [6];
  logic [5:0] pf = '0;

  frame_router uut (
    .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_dat(rx_dat), .rx_frm(rx_frm),
    .tx_stb(tx_stb), .tx_dat(tx_dat), .tx_frm(tx_frm), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_code(tbl_code), .irq(irq), .irq_ack(irq_ack),
    .frame_data(frame_data), .frame_len(frame_len), .drop_cnt(drop_cnt)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial for (int o = 0; o < 6; o++) begin
    clen[o] = 0; starts[o] = 0; first_cyc[o] = 0; last_cyc[o] = 0; cap[o] = '0;
  end

  always @(negedge clk) begin
    for (int o = 0; o < 6; o++) begin
      if (tx_frm[o] && !pf[o]) begin
        clen[o] = 0;
        starts[o] = starts[o] + 1;
      end
      if (tx_stb[o]) begin
        if (clen[o] < 128) cap[o][clen[o]] = tx_dat[o];
        if (clen[o] == 0) first_cyc[o] = cyc;
        last_cyc[o] = cyc;
        clen[o] = clen[o] + 1;
      end
      pf[o] = tx_frm[o];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [3:0] a, input logic [123:0] pay);
    mk = {pay, a[0], a[1], a[2], a[3]};
  endfunction

  function automatic logic [127:0] lo(input logic [127:0] v, input int n);
    lo = v & ((128'd1 << n) - 128'd1);
  endfunction

  function automatic int dc(input int p);
    dc = int'(drop_cnt[p*8 +: 8]);
  endfunction

  function automatic int total_starts();
    total_starts = 0;
    for (int o = 0; o < 6; o++) total_starts += starts[o];
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [2:0] code);
    @(negedge clk); tbl_we = 1'b1; tbl_idx = idx; tbl_code = code;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic send(input int p, input logic [127:0] b, input int n, input int gap,
                      output int c4, output int cl);
    c4 = 0; cl = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_stb[p] = 1'b1; rx_dat[p] = b[k]; rx_frm[p] = 1'b1;
      if (k == 3) c4 = cyc;
      cl = cyc;
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        rx_stb[p] = 1'b0;
      end
    end
    @(negedge clk);
    rx_stb[p] = 1'b0; rx_frm[p] = 1'b0; rx_dat[p] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk(tx_frm == 6'b0 && tx_stb == 6'b0, "R1 tx idle", {tx_frm, tx_stb}, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(frame_len == 7'd0, "R1 frame_len", frame_len, 0);
    chk(drop_cnt == 48'd0, "R1 drop counters", drop_cnt, 0);
  endtask

  task automatic t_forward();
    logic [127:0] b; int c4, cl, s;
    wr(4'hA, 3'd2);
    b = mk(4'hA, 124'h35A);
    s = starts[2];
    send(0, b, 12, 6, c4, cl);
    chk(starts[2] == s + 1, "R2 R12 address A routed to link 2", starts[2], s + 1);
    chk(clen[2] == 12, "R3 bit count", clen[2], 12);
    chk(lo(cap[2], 12) == lo(b, 12), "R3 bits incl address", lo(cap[2], 12), lo(b, 12));
    chk(first_cyc[2] == c4 + 1, "R3 first bit cycle", first_cyc[2], c4 + 1);
    chk(last_cyc[2] == cl + 1, "R4 data bit one cycle late", last_cyc[2], cl + 1);
    chk(tx_frm[2] == 1'b0, "R5 frame-valid released", tx_frm[2], 0);
    chk(dc(0) == 0, "R6 no drop on free link", dc(0), 0);
  endtask

  task automatic t_burst();
    logic [127:0] b; int c4, cl;
    wr(4'h3, 3'd5);
    b = mk(4'h3, 124'hBEEF);
    send(3, b, 20, 1, c4, cl);
    chk(clen[5] == 20 && lo(cap[5], 20) == lo(b, 20), "R3 back-to-back frame",
        lo(cap[5], 20), lo(b, 20));
    chk(first_cyc[5] == c4 + 1, "R3 first bit cycle, burst", first_cyc[5], c4 + 1);
    chk(last_cyc[5] == cl + 4, "R3 one queued bit per cycle", last_cyc[5], cl + 4);
  endtask

  task automatic t_busy();
    logic [127:0] b1, b2; int c4a, cla, c4b, clb, s;
    wr(4'h1, 3'd4);
    b1 = mk(4'h1, 124'h9C3_5A1);
    b2 = mk(4'h1, 124'hF0);
    s = starts[4];
    fork
      send(1, b1, 24, 8, c4a, cla);
      begin
        repeat (40) @(negedge clk);
        send(2, b2, 8, 1, c4b, clb);
      end
    join
    chk(dc(2) == 1, "R6 drop counted on receiving link", dc(2), 1);
    chk(dc(1) == 0, "R6 owner not counted", dc(1), 0);
    chk(starts[4] == s + 1 && clen[4] == 24 && lo(cap[4], 24) == lo(b1, 24),
        "R6 frame in progress intact", lo(cap[4], 24), lo(b1, 24));
  endtask

  task automatic t_tie();
    logic [127:0] b3, b4; int c4a, cla, c4b, clb;
    wr(4'h5, 3'd1);
    b3 = mk(4'h5, 124'h0F);
    b4 = mk(4'h5, 124'hF0);
    fork
      send(3, b3, 10, 2, c4a, cla);
      send(4, b4, 10, 2, c4b, clb);
    join
    chk(dc(4) == 1 && dc(3) == 0, "R7 higher link dropped", {dc(3), dc(4)}, 1);
    chk(clen[1] == 10 && lo(cap[1], 10) == lo(b3, 10), "R7 lowest link wins",
        lo(cap[1], 10), lo(b3, 10));
  endtask

  task automatic t_local();
    logic [127:0] b, b0; int c4, cl;
    wr(4'h6, 3'd7);
    b = mk(4'h6, 124'hABCD);
    send(5, b, 20, 3, c4, cl);
    chk(irq == 1'b1, "R8 irq raised", irq, 1);
    chk(frame_len == 7'd20, "R8 length", frame_len, 20);
    chk(frame_data[19:0] == b[19:0], "R8 buffer bits", frame_data[19:0], b[19:0]);
    b0 = mk(4'h6, 124'h1234);
    send(0, b0, 12, 1, c4, cl);
    chk(dc(0) == 1, "R9 second local frame dropped", dc(0), 1);
    chk(frame_data[19:0] == b[19:0] && frame_len == 7'd20, "R9 buffer unchanged",
        frame_data[19:0], b[19:0]);
    chk(irq == 1'b1, "R9 irq held", irq, 1);
    ack();
    chk(irq == 1'b0, "R9 irq cleared by ack", irq, 0);
  endtask

  task automatic t_long();
    logic [127:0] b; int c4, cl;
    b = mk(4'h6, {31'h5A5A_1234, 31'h6C3A_9E17, 31'h3A5C_9E11, 31'h1E0F_C3A5});
    send(2, b, 70, 1, c4, cl);
    chk(frame_len == 7'd64, "R10 length saturates", frame_len, 64);
    chk(frame_data == b[63:0], "R10 first 64 bits kept", frame_data, b[63:0]);
    ack();
  endtask

  task automatic t_discard();
    logic [127:0] b; int c4, cl, tot, d2, s2;
    tot = total_starts();
    d2 = dc(2);
    send(2, mk(4'h7, 124'h3F), 10, 1, c4, cl);
    chk(total_starts() == tot, "R11 R1 default code discards", total_starts(), tot);
    chk(dc(2) == d2 && irq == 1'b0, "R11 discard not counted", dc(2), d2);
    s2 = starts[2];
    send(0, mk(4'hA, 124'h0), 3, 1, c4, cl);
    b = mk(4'hA, 124'hC6);
    send(0, b, 8, 1, c4, cl);
    chk(starts[2] == s2 + 1 && clen[2] == 8 && lo(cap[2], 8) == lo(b, 8),
        "R11 short frame ignored", lo(cap[2], 8), lo(b, 8));
  endtask

  task automatic t_rewrite();
    logic [127:0] b; int c4, cl, s0, s2;
    wr(4'hA, 3'd0);
    s0 = starts[0]; s2 = starts[2];
    b = mk(4'hA, 124'h59);
    send(1, b, 8, 2, c4, cl);
    chk(starts[0] == s0 + 1 && starts[2] == s2, "R12 new entry used",
        {starts[0], starts[2]}, {s0 + 1, s2});
    chk(lo(cap[0], 8) == lo(b, 8), "R12 data on new link", lo(cap[0], 8), lo(b, 8));
  endtask

  task automatic t_saturate();
    logic [127:0] b; int c4, cl;
    wr(4'h9, 3'd3);
    b = mk(4'h9, 124'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rx_stb[0] = 1'b1; rx_dat[0] = b[k]; rx_frm[0] = 1'b1;
    end
    @(negedge clk); rx_stb[0] = 1'b0;
    for (int n = 0; n < 260; n++) send(1, b, 4, 1, c4, cl);
    chk(dc(1) == 255, "R13 counter saturates", dc(1), 255);
    @(negedge clk); rx_frm[0] = 1'b0;
    repeat (12) @(negedge clk);
    chk(tx_frm[3] == 1'b0, "R5 held link released", tx_frm[3], 0);
  endtask

  initial begin
    bit timeout = 1'b0;
    rst_n = 1'b0; rx_stb = '0; rx_dat = '0; rx_frm = '0;
    tbl_we = 1'b0; tbl_idx = '0; tbl_code = '0; irq_ack = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset(); t_forward(); t_burst(); t_busy(); t_tie();
        t_local(); t_long(); t_discard(); t_rewrite(); t_saturate();
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog (all requirements)", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule